// File: doc/BRIEF.md
# Dual-Rail Adiabatic Full-Adder Cell Emulator

This block is a cycle-based, synthesizable stand-in for a dual-rail adiabatic full-adder gate pair that is powered by a single power-clock phase. Each of the three operands (A, B and carry-in) arrives on two rails, a true rail and a complement rail. Every rail carries a 4-bit symbolic signal code and a 2-bit phase tag. The block produces the sum and carry-out, again each on a true rail and a complement rail, and the output codes follow the power-clock segment that the environment announces.

The environment drives the segment that is being entered on `seg` and pulses `segStep` for one cycle at each segment boundary. The segments run in the order charge, hold, recover, idle. On a charge step the gate evaluates its inputs. It first confirms that every input rail is tagged with the phase just before the gate's own phase, and that every operand pair holds a clean, complementary driven value. Any failure turns all four output rails into the unknown code. Through hold the outputs do not move. Recover lowers each code to its recovery-strength form, and idle discharges every rail. Each output rail is tagged with the gate's own phase, so that the next stage can run the same check.

Top module: `adb_full_adder`

## Requirements
- R1: Rail packing is code in bits [5:2] and phase tag in bits [1:0]. The codes are: 0 driven-U, 1 driven-X, 2 driven-0, 3 driven-1, 4 driven-Z, 5 recovery-u, 6 recovery-x, 7 recovery-L, 8 recovery-H, 9 recovery-z, 10 discharged. The segment codes are 0 charge, 1 hold, 2 recover, 3 idle. While `rstN` is low and right after reset, all four output rails read code 10 with tag 0.
- R2: On a charge step with valid inputs, the true rails carry sum = A^B^Ci and carry = majority(A,B,Ci), computed from the true inputs. The complement rails carry the complement of each, computed from the complement inputs alone as Sn = An^Bn^Cin and Con = (An|Bn)&(An|Cin)&(Bn|Cin). Logic 1 is code 3 and logic 0 is code 2.
- R3: On a hold step the outputs keep their values, even when the inputs have changed.
- R4: On a recover step each output keeps its logic value at recovery strength: code 2 becomes 7 and code 3 becomes 8.
- R5: On an idle step every output rail becomes code 10.
- R6: On a charge step where any input tag differs from (gatePhase-1) mod 4, all four output rails become code 1.
- R7: On a charge step where any input rail has a code other than 2 or 3 (for example 1, 0 or a recovery code), all four output rails become code 1.
- R8: On a charge step where an operand's true and complement rails carry the same logic value, all four output rails become code 1.
- R9: After every step, each output rail's tag equals `gatePhase`. With `gatePhase` 0, inputs tagged 3 count as correctly phased.
- R10: While `segStep` is low, the outputs stay unchanged whatever `seg`, `gatePhase` and the inputs do.
- R11: On a recover step, an output holding code 1 becomes code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| segStep | input | 1 | One-cycle strobe marking entry into the segment on `seg` |
| seg | input | 2 | Power-clock segment being entered |
| gatePhase | input | 2 | Phase index of the gate's own power clock |
| aTrue | input | 6 | Operand A true rail (code, tag) |
| aComp | input | 6 | Operand A complement rail |
| bTrue | input | 6 | Operand B true rail |
| bComp | input | 6 | Operand B complement rail |
| cTrue | input | 6 | Carry-in true rail |
| cComp | input | 6 | Carry-in complement rail |
| sumTrue | output | 6 | Sum true rail |
| sumComp | output | 6 | Sum complement rail |
| carryTrue | output | 6 | Carry-out true rail |
| carryComp | output | 6 | Carry-out complement rail |

## Verification
Phase checking and value checking both act in the same charge evaluation, so both can fault at once. The bench provokes this by presenting a rail pair whose two rails agree, with a mistagged operand on the same charge step. It also presents perfectly formed logic values that carry a wrong tag. In each case all four output rails must read unknown, with the gate's own tag, and the unknown must then drop to recovery-x on the following recover step. Separately, a pair the bench changes during hold must leave the held sum and carry untouched.

// File: rtl/adb_pkg.sv
package adb_pkg;
  parameter int CODE_W = 4;
  parameter int TAG_W  = 2;
  parameter int SEG_W  = 2;
  parameter int NUM_IN = 3;
  localparam int RAIL_W = CODE_W + TAG_W;

  typedef enum logic [CODE_W-1:0] {
    SIG_U   = 4'd0,
    SIG_X   = 4'd1,
    SIG_0   = 4'd2,
    SIG_1   = 4'd3,
    SIG_Z   = 4'd4,
    SIG_RU  = 4'd5,
    SIG_RX  = 4'd6,
    SIG_RL  = 4'd7,
    SIG_RH  = 4'd8,
    SIG_RZ  = 4'd9,
    SIG_DIS = 4'd10
  } sigCode_t;

  typedef enum logic [SEG_W-1:0] {
    SEG_CHG = 2'd0,
    SEG_HLD = 2'd1,
    SEG_REC = 2'd2,
    SEG_IDL = 2'd3
  } seg_t;

  typedef struct packed {
    sigCode_t         code;
    logic [TAG_W-1:0] tag;
  } rail_t;

  typedef struct packed {
    logic doEval;
    logic doRecover;
    logic doIdle;
    logic phaseBad;
  } ctrlStrobe_t;

  // Lower a driven code to its recovery-strength counterpart.
  function automatic sigCode_t toRecovery(input sigCode_t c);
    sigCode_t r;
    case (c)
      SIG_U:   r = SIG_RU;
      SIG_X:   r = SIG_RX;
      SIG_0:   r = SIG_RL;
      SIG_1:   r = SIG_RH;
      SIG_Z:   r = SIG_RZ;
      default: r = c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/adb_ctrl.sv
module adb_ctrl
  import adb_pkg::*;
(
  input  logic                    segStep,
  input  seg_t                    seg,
  input  logic [TAG_W-1:0]        gatePhase,
  input  rail_t [NUM_IN-1:0]      inTrue,
  input  rail_t [NUM_IN-1:0]      inComp,
  output ctrlStrobe_t             strobe
);
  localparam logic [TAG_W-1:0] ONE_PH = TAG_W'(1);

  logic [TAG_W-1:0]  wantTag;
  logic [NUM_IN-1:0] tagMissT;
  logic [NUM_IN-1:0] tagMissC;

  assign wantTag = gatePhase - ONE_PH;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_tag
    assign tagMissT[gi] = inTrue[gi].tag != wantTag;
    assign tagMissC[gi] = inComp[gi].tag != wantTag;
  end

  always_comb begin
    strobe.doEval    = segStep && (seg == SEG_CHG);
    strobe.doRecover = segStep && (seg == SEG_REC);
    strobe.doIdle    = segStep && (seg == SEG_IDL);
    strobe.phaseBad  = |{tagMissT, tagMissC};
  end
endmodule

// File: rtl/adb_dp.sv
module adb_dp
  import adb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [TAG_W-1:0]   gatePhase,
  input  logic               anyStep,
  input  rail_t [NUM_IN-1:0] inTrue,
  input  rail_t [NUM_IN-1:0] inComp,
  output rail_t              sumT,
  output rail_t              sumC,
  output rail_t              carT,
  output rail_t              carC
);
  logic [NUM_IN-1:0] tv, cv, pairOk;
  logic sumTv, sumCv, carTv, carCv, faultAny;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_pair
    logic tKnown, cKnown;
    assign tKnown     = (inTrue[gi].code == SIG_0) || (inTrue[gi].code == SIG_1);
    assign cKnown     = (inComp[gi].code == SIG_0) || (inComp[gi].code == SIG_1);
    assign tv[gi]     = inTrue[gi].code == SIG_1;
    assign cv[gi]     = inComp[gi].code == SIG_1;
    assign pairOk[gi] = tKnown && cKnown && (tv[gi] != cv[gi]);
  end

  // True network from true inputs, dual network from complement inputs.
  assign sumTv = tv[0] ^ tv[1] ^ tv[2];
  assign carTv = (tv[0] & tv[1]) | (tv[0] & tv[2]) | (tv[1] & tv[2]);
  assign sumCv = cv[0] ^ cv[1] ^ cv[2];
  assign carCv = (cv[0] | cv[1]) & (cv[0] | cv[2]) & (cv[1] | cv[2]);

  assign faultAny = strobe.phaseBad || !(&pairOk);

  function automatic sigCode_t lvl(input logic b);
    return b ? SIG_1 : SIG_0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumT <= '{code: SIG_DIS, tag: '0};
      sumC <= '{code: SIG_DIS, tag: '0};
      carT <= '{code: SIG_DIS, tag: '0};
      carC <= '{code: SIG_DIS, tag: '0};
    end else begin
      if (anyStep) begin
        sumT.tag <= gatePhase;
        sumC.tag <= gatePhase;
        carT.tag <= gatePhase;
        carC.tag <= gatePhase;
      end
      if (strobe.doEval) begin
        if (faultAny) begin
          sumT.code <= SIG_X;
          sumC.code <= SIG_X;
          carT.code <= SIG_X;
          carC.code <= SIG_X;
        end else begin
          sumT.code <= lvl(sumTv);
          sumC.code <= lvl(sumCv);
          carT.code <= lvl(carTv);
          carC.code <= lvl(carCv);
        end
      end else if (strobe.doRecover) begin
        sumT.code <= toRecovery(sumT.code);
        sumC.code <= toRecovery(sumC.code);
        carT.code <= toRecovery(carT.code);
        carC.code <= toRecovery(carC.code);
      end else if (strobe.doIdle) begin
        sumT.code <= SIG_DIS;
        sumC.code <= SIG_DIS;
        carT.code <= SIG_DIS;
        carC.code <= SIG_DIS;
      end
    end
  end

  // R11: an unknown output weakens to recovery-x
  assert_unknown_recovers_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRecover && sumT.code == SIG_X) |=> (sumT.code == SIG_RX));
endmodule

// File: rtl/adb_full_adder.sv
module adb_full_adder
  import adb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 segStep,
  input  logic [SEG_W-1:0]     seg,
  input  logic [TAG_W-1:0]     gatePhase,
  input  logic [RAIL_W-1:0]    aTrue,
  input  logic [RAIL_W-1:0]    aComp,
  input  logic [RAIL_W-1:0]    bTrue,
  input  logic [RAIL_W-1:0]    bComp,
  input  logic [RAIL_W-1:0]    cTrue,
  input  logic [RAIL_W-1:0]    cComp,
  output logic [RAIL_W-1:0]    sumTrue,
  output logic [RAIL_W-1:0]    sumComp,
  output logic [RAIL_W-1:0]    carryTrue,
  output logic [RAIL_W-1:0]    carryComp
);
  rail_t [NUM_IN-1:0] inTrue, inComp;
  rail_t sumT, sumC, carT, carC;
  ctrlStrobe_t strobe;

  assign inTrue = {rail_t'(cTrue), rail_t'(bTrue), rail_t'(aTrue)};
  assign inComp = {rail_t'(cComp), rail_t'(bComp), rail_t'(aComp)};

  adb_ctrl u_ctrl (
    .segStep   (segStep),
    .seg       (seg_t'(seg)),
    .gatePhase (gatePhase),
    .inTrue    (inTrue),
    .inComp    (inComp),
    .strobe    (strobe)
  );

  adb_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .gatePhase (gatePhase),
    .anyStep   (segStep),
    .inTrue    (inTrue),
    .inComp    (inComp),
    .sumT      (sumT),
    .sumC      (sumC),
    .carT      (carT),
    .carC      (carC)
  );

  assign sumTrue   = sumT;
  assign sumComp   = sumC;
  assign carryTrue = carT;
  assign carryComp = carC;

  // R2: after a charge step the two sum rails never claim the same logic level
  assert_dual_rail_R2: assert property (@(posedge clk) disable iff (!rstN)
    (segStep && seg == SEG_CHG) |=>
      ((sumTrue[5:2] == 4'd3) == (sumComp[5:2] == 4'd2)) &&
      ((carryTrue[5:2] == 4'd3) == (carryComp[5:2] == 4'd2)));

  // R3: hold keeps every rail
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (segStep && seg == SEG_HLD) |=>
      $stable({sumTrue, sumComp, carryTrue, carryComp}));

  // R4: a driven one drops to recovery-high
  assert_recover_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (segStep && seg == SEG_REC && carryTrue[5:2] == 4'd3) |=> (carryTrue[5:2] == 4'd8));

  // R5: idle discharges all rails
  assert_idle_discharge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (segStep && seg == SEG_IDL) |=>
      (sumTrue[5:2] == 4'd10 && sumComp[5:2] == 4'd10 &&
       carryTrue[5:2] == 4'd10 && carryComp[5:2] == 4'd10));

  // R6: a mistagged operand A forces unknown
  assert_phase_error_R6: assert property (@(posedge clk) disable iff (!rstN)
    (segStep && seg == SEG_CHG && aTrue[1:0] != gatePhase - 2'd1) |=>
      (sumTrue[5:2] == 4'd1 && carryComp[5:2] == 4'd1));

  // R9: output tags follow the gate phase
  assert_out_tag_R9: assert property (@(posedge clk) disable iff (!rstN)
    segStep |=> (sumTrue[1:0] == $past(gatePhase) && carryComp[1:0] == $past(gatePhase)));

  // R10: no strobe, no change
  assert_idle_no_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    !segStep |=> $stable({sumTrue, sumComp, carryTrue, carryComp}));
endmodule

// File: tb/adb_full_adder_tb.sv
module adb_full_adder_tb;
  logic clk = 0;
  logic rstN = 0;
  logic segStep = 0;
  logic [1:0] seg = 0;
  logic [1:0] gatePhase = 0;
  logic [5:0] aTrue, aComp, bTrue, bComp, cTrue, cComp;
  logic [5:0] sumTrue, sumComp, carryTrue, carryComp;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adb_full_adder u_dut (
    .clk(clk), .rstN(rstN), .segStep(segStep), .seg(seg), .gatePhase(gatePhase),
    .aTrue(aTrue), .aComp(aComp), .bTrue(bTrue), .bComp(bComp),
    .cTrue(cTrue), .cComp(cComp),
    .sumTrue(sumTrue), .sumComp(sumComp), .carryTrue(carryTrue), .carryComp(carryComp)
  );

  function automatic logic [5:0] rl(input logic [3:0] code, input logic [1:0] tag);
    return {code, tag};
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d/%0d expected=%0d/%0d", req, act[5:2], act[1:0], exp[5:2], exp[1:0]);
    end
  endtask

  task automatic chkAll(input string req, input logic [5:0] eS, input logic [5:0] eSn,
                        input logic [5:0] eC, input logic [5:0] eCn);
    chk({req, " sumTrue"}, sumTrue, eS);
    chk({req, " sumComp"}, sumComp, eSn);
    chk({req, " carryTrue"}, carryTrue, eC);
    chk({req, " carryComp"}, carryComp, eCn);
  endtask

  task automatic setOps(input logic a, input logic b, input logic c, input logic [1:0] tag);
    @(negedge clk);
    aTrue = rl(a ? 4'd3 : 4'd2, tag); aComp = rl(a ? 4'd2 : 4'd3, tag);
    bTrue = rl(b ? 4'd3 : 4'd2, tag); bComp = rl(b ? 4'd2 : 4'd3, tag);
    cTrue = rl(c ? 4'd3 : 4'd2, tag); cComp = rl(c ? 4'd2 : 4'd3, tag);
  endtask

  task automatic stepSeg(input logic [1:0] s);
    @(negedge clk);
    seg = s; segStep = 1;
    @(negedge clk);
    segStep = 0;
  endtask

  task automatic t_reset();
    // R1: discharged with tag 0
    rstN = 0;
    repeat (3) @(negedge clk);
    chkAll("R1 reset", rl(10, 0), rl(10, 0), rl(10, 0), rl(10, 0));
    rstN = 1;
    @(negedge clk);
    chkAll("R1 after reset", rl(10, 0), rl(10, 0), rl(10, 0), rl(10, 0));
  endtask

  task automatic t_truth();
    gatePhase = 2'd1;
    for (int v = 0; v < 8; v++) begin
      logic a, b, c, s, co;
      a = v[2]; b = v[1]; c = v[0];
      s = a ^ b ^ c; co = (a & b) | (a & c) | (b & c);
      setOps(a, b, c, 2'd0);
      stepSeg(2'd0);
      chkAll("R2 charge", rl(s ? 3 : 2, 1), rl(s ? 2 : 3, 1), rl(co ? 3 : 2, 1), rl(co ? 2 : 3, 1));
      stepSeg(2'd1);
      chkAll("R3 hold", rl(s ? 3 : 2, 1), rl(s ? 2 : 3, 1), rl(co ? 3 : 2, 1), rl(co ? 2 : 3, 1));
      stepSeg(2'd2);
      chkAll("R4 recover", rl(s ? 8 : 7, 1), rl(s ? 7 : 8, 1), rl(co ? 8 : 7, 1), rl(co ? 7 : 8, 1));
      stepSeg(2'd3);
      chkAll("R5 idle", rl(10, 1), rl(10, 1), rl(10, 1), rl(10, 1));
    end
  endtask

  task automatic t_holdChange();
    gatePhase = 2'd2;
    setOps(1, 1, 0, 2'd1);
    stepSeg(2'd0);
    setOps(0, 0, 1, 2'd1);
    stepSeg(2'd1);
    chkAll("R3 hold after input change", rl(2, 2), rl(3, 2), rl(3, 2), rl(2, 2));
  endtask

  task automatic t_noStep();
    // outputs from t_holdChange remain; wiggle everything without a strobe
    @(negedge clk);
    seg = 2'd3; gatePhase = 2'd0;
    setOps(1, 1, 1, 2'd3);
    repeat (4) @(negedge clk);
    chkAll("R10 no step", rl(2, 2), rl(3, 2), rl(3, 2), rl(2, 2));
    stepSeg(2'd3);
  endtask

  task automatic t_phaseError();
    gatePhase = 2'd3;
    setOps(1, 0, 1, 2'd2);
    @(negedge clk); bComp[1:0] = 2'd1;
    stepSeg(2'd0);
    chkAll("R6 phase mismatch", rl(1, 3), rl(1, 3), rl(1, 3), rl(1, 3));
    stepSeg(2'd1);
    stepSeg(2'd2);
    chkAll("R11 unknown recovers", rl(6, 3), rl(6, 3), rl(6, 3), rl(6, 3));
    stepSeg(2'd3);
  endtask

  task automatic t_unknownCode();
    gatePhase = 2'd1;
    setOps(0, 1, 1, 2'd0);
    @(negedge clk); cTrue[5:2] = 4'd1;
    stepSeg(2'd0);
    chkAll("R7 unknown input", rl(1, 1), rl(1, 1), rl(1, 1), rl(1, 1));
    stepSeg(2'd3);
    setOps(1, 1, 0, 2'd0);
    @(negedge clk); aTrue[5:2] = 4'd8;
    stepSeg(2'd0);
    chkAll("R7 recovery code input", rl(1, 1), rl(1, 1), rl(1, 1), rl(1, 1));
    stepSeg(2'd3);
  endtask

  task automatic t_conflict();
    gatePhase = 2'd1;
    setOps(1, 0, 0, 2'd0);
    @(negedge clk); aComp[5:2] = 4'd3;
    stepSeg(2'd0);
    chkAll("R8 rail conflict", rl(1, 1), rl(1, 1), rl(1, 1), rl(1, 1));
    stepSeg(2'd3);
    // conflict and phase error together
    setOps(0, 1, 0, 2'd0);
    @(negedge clk); bComp[5:2] = 4'd3; cTrue[1:0] = 2'd2;
    stepSeg(2'd0);
    chkAll("R8 R6 combined fault", rl(1, 1), rl(1, 1), rl(1, 1), rl(1, 1));
    stepSeg(2'd3);
  endtask

  task automatic t_wrap();
    gatePhase = 2'd0;
    setOps(1, 1, 1, 2'd3);
    stepSeg(2'd0);
    chkAll("R9 phase wrap", rl(3, 0), rl(2, 0), rl(3, 0), rl(2, 0));
    stepSeg(2'd3);
  endtask

  initial begin
    aTrue = 0; aComp = 0; bTrue = 0; bComp = 0; cTrue = 0; cComp = 0;
    t_reset();
    t_truth();
    t_holdChange();
    t_noStep();
    t_phaseError();
    t_unknownCode();
    t_conflict();
    t_wrap();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule